// File: doc/BRIEF.md
# Two-Wire Serial Bus Controller

This block is a single-master controller for a two-wire serial bus with open-drain clock and data lines. A host starts an operation with a one-cycle command strobe. Three operations exist. START also serves as a repeated START while the controller holds the bus. STOP releases the bus. A byte transfer shifts eight bits out on the data line and captures eight bits back from it. Reads and writes therefore use the same command: to read, the host sends all ones and the target pulls bits low. A ninth clock carries the acknowledge.

Every bit period has four equal quarters. The length of a quarter comes from one of eight fixed divide values, chosen by a 3-bit selector. The block never drives a line high. It only enables a pull-down, and external pull-ups supply the high level. A level interrupt tells the host that the controller is enabled and idle. Clearing the enable input aborts the current operation at once.

Top module: `i2c_ctl`

## Requirements
- R1: A START command (`cmd_op`=01) takes four quarters. It releases SDA, then releases SCL, then pulls SDA low while SCL is released, then pulls SCL low. The controller keeps SCL low afterwards. Issued while the bus is held, the same command forms a repeated START.
- R2: A STOP command (`cmd_op`=10) pulls SDA low, then releases SCL, then releases SDA while SCL is released. It ends with both lines released and takes four quarters.
- R3: A byte transfer (`cmd_op`=11) is issued after a START. It runs nine SCL clocks, four quarters each, for 36 quarters in total. In each data bit, `tx_byte` is sent most significant bit first. SDA changes in the first quarter while SCL is low. SCL is released in the second quarter, the line is sampled in the third, and SCL is pulled low in the fourth. The eight sampled bits form `rx_byte`, first bit in the MSB.
- R4: In the ninth bit, SDA is pulled low if `ack_drive` was 1 when the command was accepted, and released otherwise. The sampled level is reported in `ack_bit`, where 0 means acknowledged.
- R5: `prescale_sel` codes 0 to 7 select quarter lengths of 2, 4, 8, 64, 128, 1024, 2048 and 4096 system clocks. The code is latched when a command is accepted. START and STOP end 4×div cycles after the acceptance edge, and a byte transfer ends 36×div cycles after it.
- R6: `scl_oe` and `sda_oe` are pull-down enables, where 1 means the line is pulled low. A released line reads high only through the external pull-up.
- R7: A low `enable` sampled at a clock edge clears `busy` and releases both lines at that edge, whatever the controller was doing.
- R8: `irq` is registered. It is 1 exactly when the controller is enabled and not busy. It falls at the edge that accepts a command, and it is 0 while `enable` is low.
- R9: A command (`cmd_op` other than 00 with `cmd_valid` high) is accepted only when the controller is enabled and not busy. Any other command is ignored and has no effect on the lines or on timing.
- R10: `rx_byte` and `ack_bit` change only at the edge where a byte transfer completes. An aborted transfer leaves them unchanged.
- R11: Synchronous active-high reset clears `busy`, `irq`, `rx_byte`, `ack_bit`, and both pull-down enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; low aborts |
| prescale_sel | input | 3 | Quarter-length selector |
| ack_drive | input | 1 | Pull SDA low in the ninth bit |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 none, 01 START, 10 STOP, 11 byte transfer |
| tx_byte | input | DATA_W | Byte to send |
| sda_in | input | 1 | Sensed level of the data line |
| scl_oe | output | 1 | Pull clock line low |
| sda_oe | output | 1 | Pull data line low |
| busy | output | 1 | Operation in progress |
| rx_byte | output | DATA_W | Byte captured by the last completed transfer |
| ack_bit | output | 1 | Acknowledge level sampled in the last ninth bit |
| irq | output | 1 | Enabled-and-idle level |

## Verification
Some properties are checked by assertions on every cycle:
- during a byte transfer, SDA changes only while SCL is held low;
- the interrupt and busy are never both high;
- disabling releases both lines on the next cycle;
- the operation code stays fixed while busy;
- the received data changes only on the cycle busy falls;
- prescaler ticks never come back to back.

Other behaviour only the bench scenarios can show: START and STOP conditions as seen on the wired lines, the values of received bytes and acknowledges from a modelled target, the exact length of each operation for every divide code, and commands ignored while busy or disabled.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int PRE_W = 12;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_START = 2'b01,
    OP_STOP  = 2'b10,
    OP_XFER  = 2'b11
  } op_e;

  // quarter length minus one for each selector code
  function automatic logic [PRE_W-1:0] pre_limit(input logic [2:0] sel);
    logic [PRE_W-1:0] r;
    case (sel)
      3'd0:    r = 12'd1;
      3'd1:    r = 12'd3;
      3'd2:    r = 12'd7;
      3'd3:    r = 12'd63;
      3'd4:    r = 12'd127;
      3'd5:    r = 12'd1023;
      3'd6:    r = 12'd2047;
      default: r = 12'd4095;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/i2c_ctl_tick.sv
module i2c_ctl_tick
  import i2c_ctl_pkg::*;
#(
  parameter int CW = PRE_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lim <= '0;
    end else begin
      if (load) lim <= CW'(pre_limit(sel));
      if (!run)            cnt <= '0;
      else if (cnt == lim) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == lim);

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R5
endmodule

// File: rtl/i2c_ctl_seq.sv
module i2c_ctl_seq
  import i2c_ctl_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [BITS-1:0] tx_byte,
  input  logic            ack_drive,
  input  logic            sda_in,
  input  logic            tick,
  output logic            accept,
  output logic            busy,
  output logic            scl_oe,
  output logic            sda_oe,
  output logic [BITS-1:0] rx_byte,
  output logic            ack_bit,
  output logic            irq
);
  localparam int BW = $clog2(BITS + 1);

  op_e             op_q;
  logic [1:0]      q;
  logic [BW-1:0]   bitn;
  logic [BITS-1:0] shreg;
  logic            ack_en_q;
  logic            ack_tmp;
  logic            last;

  assign accept = enable && !busy && cmd_valid && (cmd_op != OP_NONE);
  assign last   = (bitn == BW'(BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      op_q     <= OP_NONE;
      q        <= '0;
      bitn     <= '0;
      shreg    <= '0;
      ack_en_q <= 1'b0;
      ack_tmp  <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      rx_byte  <= '0;
      ack_bit  <= 1'b0;
      irq      <= 1'b0;
    end else if (!enable) begin
      busy   <= 1'b0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      irq    <= 1'b0;
    end else if (!busy) begin
      irq <= !accept;
      if (accept) begin
        busy     <= 1'b1;
        op_q     <= op_e'(cmd_op);
        q        <= '0;
        bitn     <= '0;
        shreg    <= tx_byte;
        ack_en_q <= ack_drive;
      end
    end else if (tick) begin
      q <= q + 2'd1;
      case (op_q)
        OP_START: begin
          unique case (q)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b1;
            2'd3: begin
              scl_oe <= 1'b1;
              busy   <= 1'b0;
              irq    <= 1'b1;
            end
          endcase
        end
        OP_STOP: begin
          unique case (q)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            2'd3: begin
              busy <= 1'b0;
              irq  <= 1'b1;
            end
          endcase
        end
        default: begin
          unique case (q)
            2'd0: sda_oe <= last ? ack_en_q : ~shreg[BITS-1];
            2'd1: scl_oe <= 1'b0;
            2'd2: begin
              if (last) ack_tmp <= sda_in;
              else      shreg   <= {shreg[BITS-2:0], sda_in};
            end
            2'd3: begin
              scl_oe <= 1'b1;
              if (last) begin
                busy    <= 1'b0;
                irq     <= 1'b1;
                rx_byte <= shreg;
                ack_bit <= ack_tmp;
                bitn    <= '0;
              end else begin
                bitn <= bitn + 1'b1;
              end
            end
          endcase
        end
      endcase
    end
  end

  AST_DATA_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (busy && op_q == OP_XFER && sda_oe != $past(sda_oe)) |-> $past(scl_oe)); // R3
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!busy && !scl_oe && !sda_oe)); // R7
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> !busy); // R8
  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(op_q)); // R9
  AST_RX_AT_END: assert property (@(posedge clk) disable iff (rst)
    (rx_byte != $past(rx_byte) || ack_bit != $past(ack_bit)) |-> ($past(busy) && !busy)); // R10
endmodule

// File: rtl/i2c_ctl.sv
module i2c_ctl
  import i2c_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [2:0]        prescale_sel,
  input  logic              ack_drive,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic [DATA_W-1:0] rx_byte,
  output logic              ack_bit,
  output logic              irq
);
  logic accept;
  logic tick;

  i2c_ctl_tick #(.CW(PRE_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .run  (busy),
    .sel  (prescale_sel),
    .tick (tick)
  );

  i2c_ctl_seq #(.BITS(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .tx_byte   (tx_byte),
    .ack_drive (ack_drive),
    .sda_in    (sda_in),
    .tick      (tick),
    .accept    (accept),
    .busy      (busy),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .rx_byte   (rx_byte),
    .ack_bit   (ack_bit),
    .irq       (irq)
  );
endmodule

// File: tb/tb_i2c_ctl.sv
`timescale 1ns/1ps
module tb_i2c_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       ack_drive = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] tx = 8'h00;
  logic       sda_in;
  logic       scl_oe, sda_oe, busy, ack_bit, irq;
  logic [7:0] rx_byte;

  always #10 clk = ~clk;

  i2c_ctl dut (
    .clk(clk), .rst(rst), .enable(enable), .prescale_sel(sel),
    .ack_drive(ack_drive), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .tx_byte(tx), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(busy), .rx_byte(rx_byte), .ack_bit(ack_bit), .irq(irq)
  );

  // wired bus with a simple target that pulls SDA per bit
  int         nfall = 0;
  int         base = 0;
  logic [8:0] pat = 9'd0;
  logic       slave_pull;
  logic       scl_line;
  int         starts = 0;
  int         stops = 0;

  assign scl_line = !scl_oe;
  always_comb begin
    int k;
    k = nfall - base;
    slave_pull = (k >= 0 && k < 9) ? pat[8-k] : 1'b0;
  end
  assign sda_in = !(sda_oe || slave_pull);

  always @(negedge scl_line) nfall++;
  always @(negedge sda_in) if (scl_line === 1'b1) starts++;
  always @(posedge sda_in) if (scl_line === 1'b1) stops++;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_busy, m_scl, m_sda, m_irq, m_ack, m_ackt, m_acken;
  int m_op, m_div, m_cnt, m_q, m_bit;
  logic [7:0] m_tx, m_rx, m_rxw;

  function automatic int div_of(input logic [2:0] s);
    int sh[8] = '{1, 2, 3, 6, 7, 10, 11, 12};
    return 1 << sh[s];
  endfunction

  task automatic quarter();
    if (m_op == 1) begin
      if (m_q == 0) m_sda = 0;
      else if (m_q == 1) m_scl = 0;
      else if (m_q == 2) m_sda = 1;
      else begin m_scl = 1; m_busy = 0; m_irq = 1; end
    end else if (m_op == 2) begin
      if (m_q == 0) m_sda = 1;
      else if (m_q == 1) m_scl = 0;
      else if (m_q == 2) m_sda = 0;
      else begin m_busy = 0; m_irq = 1; end
    end else begin
      if (m_q == 0) m_sda = (m_bit < 8) ? int'(!m_tx[7-m_bit]) : m_acken;
      else if (m_q == 1) m_scl = 0;
      else if (m_q == 2) begin
        if (m_bit < 8) m_rxw[7-m_bit] = sda_in;
        else m_ackt = int'(sda_in);
      end else begin
        m_scl = 1;
        if (m_bit == 8) begin
          m_busy = 0; m_irq = 1; m_rx = m_rxw; m_ack = m_ackt;
        end else m_bit++;
      end
    end
    m_q = (m_q + 1) % 4;
  endtask

  task automatic model_edge();
    if (rst) begin
      m_busy = 0; m_scl = 0; m_sda = 0; m_irq = 0; m_ack = 0; m_rx = 8'h00;
      m_cnt = 0; m_op = 0; m_ackt = 0;
    end else if (!enable) begin
      m_busy = 0; m_scl = 0; m_sda = 0; m_irq = 0; m_cnt = 0;
    end else if (m_busy == 0) begin
      if (cmd_valid && cmd_op != 2'b00) begin
        m_busy = 1; m_op = int'(cmd_op); m_div = div_of(sel); m_cnt = 0;
        m_q = 0; m_bit = 0; m_tx = tx; m_acken = int'(ack_drive); m_rxw = 8'h00;
      end
      m_irq = (m_busy == 0) ? 1 : 0;
    end else begin
      if (m_cnt == m_div - 1) begin
        m_cnt = 0;
        quarter();
      end else m_cnt++;
    end
  endtask

  task automatic compare();
    check("R9 busy", busy, m_busy);
    check("R3 scl_oe", scl_oe, m_scl);
    check("R3 sda_oe", sda_oe, m_sda);
    check("R8 irq", irq, m_irq);
    check("R10 rx_byte", rx_byte, m_rx);
    check("R4 ack_bit", ack_bit, m_ack);
  endtask

  task automatic step();
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic cmd(input logic [1:0] op, input logic [7:0] d, input logic ad, input logic [2:0] s);
    cmd_valid = 1'b1; cmd_op = op; tx = d; ack_drive = ad; sel = s;
    step();
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 40000) begin
      step();
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, s0, p0;
    @(negedge clk);
    repeat (3) step();
    check("R11 reset outputs", {busy, scl_oe, sda_oe, irq, ack_bit, rx_byte}, 0);
    rst = 1'b0;
    step();
    check("R8 irq low while disabled", irq, 0);
    enable = 1'b1;
    step();
    check("R8 irq high when enabled idle", irq, 1);

    // R9: disabled controller ignores commands
    enable = 1'b0;
    cmd(2'b01, 8'h00, 1'b0, 3'd0);
    repeat (10) step();
    check("R9 disabled command ignored", {busy, scl_oe, sda_oe}, 0);
    enable = 1'b1;
    step();

    // R1: START from idle bus
    s0 = starts;
    cmd(2'b01, 8'h00, 1'b0, 3'd0);
    wait_idle(n);
    check("R1 start length", n, 8);
    check("R1 start condition seen", starts - s0, 1);
    check("R1 scl held low", scl_oe, 1);

    // R3: byte with no target, data loops back
    s0 = starts; p0 = stops;
    cmd(2'b11, 8'hA5, 1'b0, 3'd0);
    wait_idle(n);
    check("R3 byte length", n, 72);
    check("R3 rx loopback", rx_byte, 8'hA5);
    check("R4 nack released", ack_bit, 1);
    check("R3 no bus conditions in byte", (starts - s0) + (stops - p0), 0);

    // R4/R5: target returns 0x36 and acknowledges, divide 4
    pat = {~8'h36, 1'b1}; base = nfall;
    cmd(2'b11, 8'hFF, 1'b0, 3'd1);
    wait_idle(n);
    check("R5 byte length div4", n, 144);
    check("R3 rx from target", rx_byte, 8'h36);
    check("R4 ack from target", ack_bit, 0);
    pat = 9'd0;

    // R9: command while busy ignored; R4 own acknowledge drive
    s0 = starts;
    cmd(2'b11, 8'h3C, 1'b1, 3'd0);
    repeat (5) step();
    cmd(2'b01, 8'h00, 1'b0, 3'd7);
    wait_idle(n);
    check("R9 busy command ignored, length", n + 6, 72);
    check("R9 no start during byte", starts - s0, 0);
    check("R3 rx 3C", rx_byte, 8'h3C);
    check("R4 own ack drive", ack_bit, 0);

    // R1 repeated START, R2 STOP
    s0 = starts; p0 = stops;
    cmd(2'b01, 8'h00, 1'b0, 3'd2);
    wait_idle(n);
    check("R5 start length div8", n, 32);
    check("R1 repeated start seen", starts - s0, 1);
    cmd(2'b10, 8'h00, 1'b0, 3'd0);
    wait_idle(n);
    check("R2 stop length", n, 8);
    check("R2 stop condition seen", stops - p0, 1);
    check("R2 lines released", {scl_oe, sda_oe}, 0);
    check("R8 irq after stop", irq, 1);

    // R5 divide table
    cmd(2'b01, 8'h00, 1'b0, 3'd3); wait_idle(n); check("R5 sel3", n, 256);
    cmd(2'b10, 8'h00, 1'b0, 3'd4); wait_idle(n); check("R5 sel4", n, 512);
    cmd(2'b01, 8'h00, 1'b0, 3'd5); wait_idle(n); check("R5 sel5", n, 4096);
    cmd(2'b10, 8'h00, 1'b0, 3'd6); wait_idle(n); check("R5 sel6", n, 8192);
    cmd(2'b01, 8'h00, 1'b0, 3'd7); wait_idle(n); check("R5 sel7", n, 16384);

    // R7 abort mid-byte, R10 received data kept
    cmd(2'b11, 8'h81, 1'b0, 3'd2);
    repeat (40) step();
    enable = 1'b0;
    step();
    check("R7 abort busy", busy, 0);
    check("R7 abort releases lines", {scl_oe, sda_oe}, 0);
    check("R8 irq low after abort", irq, 0);
    check("R10 rx kept after abort", rx_byte, 8'h3C);
    enable = 1'b1;
    step();
    check("R8 irq back after enable", irq, 1);
    check("R6 released idle lines", {scl_oe, sda_oe}, 0);
    repeat (4) step();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule